// File: doc/BRIEF.md
# Flash Row Programming Controller

This block sits between a CPU I/O bus and a flash array. Software loads a target address and then writes data bytes. Each byte is handed to the array with a program strobe, and the high-voltage enable is raised around it. The CPU is stalled through a wait output for as long as the byte takes to program, so back-to-back writes need no polling. The address is made of a column field, a row field and a page field, which are treated as one number. It advances after every access to the data register.

There are two modes. In single-byte mode the high voltage is raised for one byte and dropped when that byte is done. In row mode, which software enables through a control bit, the high voltage stays on from the first byte until the last column of the row has been programmed. The row mode then ends by itself and a completion flag is set.

A row watchdog counts time from the moment row mode is enabled. If it expires before the row is complete, the controller aborts the row and sets an error flag. Until software clears that flag, every further data write is refused.

Both the byte program time and the row budget are counted in ticks of a prescaler that software programs. The defaults give a 47-tick byte and a 31000-tick row, which match about 47 µs and 31 ms when the tick is 1 µs. Completion and error each drive the interrupt output through their own enable bit.

Top module: `flash_rowprog_ctrl`

## Requirements
- R1: After reset the high-voltage enable, program strobe, wait and interrupt are low, and every register reads 0.
- R2: The register map (offset: meaning) is as follows. Reads of offsets 1, 2, 3 and 6 return the value last written there, zero-extended. COL_W, ROW_W, PAGE_W and DIV_W are each at most 8.
  - 0: data
  - 1: column
  - 2: row
  - 3: page
  - 4: control (bit0 row mode, bit1 completion interrupt enable, bit2 time-out interrupt enable)
  - 5: status (bit0 row done, bit1 time-out)
  - 6: prescaler divide value D
- R3: A data write that is accepted holds bus_wait high for (D+1)*BYTE_TICKS cycles, so the access lasts 1+(D+1)*BYTE_TICKS cycles. Every other access completes with no wait.
- R4: Every data-register access, whether a read or an accepted write, increments the address {page,row,column} by one after the access completes. A carry out of the column propagates into the row, and from the row into the page. A data read returns the last written data byte.
- R5: In single-byte mode fl_hv is high while the byte programs and low once the access completes. fl_prog is never high without fl_hv.
- R6: In row mode fl_hv stays high between bytes. When the byte at the last column completes, row mode clears, status bit0 sets and fl_hv drops.
- R7: If row mode has been on for (D+1)*ROW_TMO_TICKS cycles without finishing, the row is aborted: fl_hv drops, row mode clears, and status bits 0 and 1 both set.
- R8: While status bit1 is set, a data write completes with no wait, starts no programming and leaves the address unchanged, and setting control bit0 has no effect.
- R9: Writing 1 to a status bit clears it. irq equals (bit0 AND control bit1) OR (bit1 AND control bit2).
- R10: While fl_prog is high, fl_addr carries the address {page,row,column} of the byte and fl_data carries the byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, held by the CPU while bus_wait is high |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| bus_wait | output | 1 | Stalls the current access |
| fl_addr | output | COL_W+ROW_W+PAGE_W | Array byte address |
| fl_data | output | 8 | Byte to program |
| fl_prog | output | 1 | Program strobe, high for the byte time |
| fl_hv | output | 1 | High-voltage enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes at the last column in single-byte mode to prove the carry into the row field. A design that wraps only the column would program the next byte over the start of the same row. A full row is written in row mode, and the high-voltage enable is sampled between bytes. A controller that toggles it per byte, or that never leaves row mode after the last column, is caught there. The bench also lets a row stall until the watchdog fires, then attempts writes. A design that keeps stalling, programming or advancing the address while the error stands is reported, as is a design that lets row mode be re-armed before the flag is cleared. Wait lengths are checked with two prescaler settings, so a divider that is off by one cycle shows up.

// File: rtl/frp_pkg.sv
package frp_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_PROG} frp_state_e;

    localparam logic [2:0] RA_DATA = 3'd0;
    localparam logic [2:0] RA_COL  = 3'd1;
    localparam logic [2:0] RA_ROW  = 3'd2;
    localparam logic [2:0] RA_PAGE = 3'd3;
    localparam logic [2:0] RA_CTRL = 3'd4;
    localparam logic [2:0] RA_STAT = 3'd5;
    localparam logic [2:0] RA_DIV  = 3'd6;

    localparam int CB_ROW     = 0;
    localparam int CB_DONE_IE = 1;
    localparam int CB_TMO_IE  = 2;
    localparam int SB_DONE    = 0;
    localparam int SB_TMO     = 1;
endpackage

// File: rtl/frp_timer.sv
// Prescaled interval timer: counts LIMIT ticks of (div+1) cycles while run is high.
module frp_timer #(
    parameter int DIV_W = 8,
    parameter int LIMIT = 47
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] T_ONE = CNT_W'(1);
    localparam logic [DIV_W-1:0] P_ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [CNT_W-1:0] ticks;
    } tmr_t;

    tmr_t t_d, t_q;
    logic tick;

    always_comb begin
        t_d    = t_q;
        tick   = run && (t_q.pre == div);
        expire = tick && (t_q.ticks == LAST);
        if (restart) begin
            t_d.pre   = '0;
            t_d.ticks = '0;
        end else if (run) begin
            if (tick) begin
                t_d.pre   = '0;
                t_d.ticks = t_q.ticks + T_ONE;
            end else begin
                t_d.pre = t_q.pre + P_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/frp_flags.sv
// Sticky completion / error flags with write-one-to-clear and gated interrupt.
module frp_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_done,
    input  logic       set_tmo,
    input  logic       clr_wr,
    input  logic [1:0] clr_mask,
    input  logic       done_ie,
    input  logic       tmo_ie,
    output logic       done_flag,
    output logic       tmo_flag,
    output logic       irq
);
    typedef struct packed {
        logic done;
        logic tmo;
    } flg_t;

    flg_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr_wr && clr_mask[0]) f_d.done = 1'b0;
        if (clr_wr && clr_mask[1]) f_d.tmo  = 1'b0;
        if (set_done) f_d.done = 1'b1;
        if (set_tmo)  f_d.tmo  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign done_flag = f_q.done;
    assign tmo_flag  = f_q.tmo;
    assign irq       = (f_q.done && done_ie) || (f_q.tmo && tmo_ie);
endmodule

// File: rtl/flash_rowprog_ctrl.sv
module flash_rowprog_ctrl
    import frp_pkg::*;
#(
    parameter int COL_W         = 8,
    parameter int ROW_W         = 7,
    parameter int PAGE_W        = 2,
    parameter int DIV_W         = 8,
    parameter int BYTE_TICKS    = 47,
    parameter int ROW_TMO_TICKS = 31000,
    localparam int ADDR_W       = COL_W + ROW_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_wait,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_data,
    output logic              fl_prog,
    output logic              fl_hv,
    output logic              irq
);
    localparam int ROW_LSB = COL_W;
    localparam int PG_LSB  = COL_W + ROW_W;
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        frp_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [DIV_W-1:0]  div;
        logic              row_mode;
        logic              done_ie;
        logic              tmo_ie;
        logic              hv;
    } ctl_t;

    ctl_t r_d, r_q;

    logic byte_start, byte_done, row_start, row_expire;
    logic set_done, set_tmo, clr_wr;
    logic done_flag, tmo_flag;
    logic col_last, finishing_row;

    frp_timer #(.DIV_W(DIV_W), .LIMIT(BYTE_TICKS)) u_byte_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (byte_start),
        .run     (r_q.st == ST_PROG),
        .div     (r_q.div),
        .expire  (byte_done)
    );

    frp_timer #(.DIV_W(DIV_W), .LIMIT(ROW_TMO_TICKS)) u_row_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (row_start),
        .run     (r_q.row_mode),
        .div     (r_q.div),
        .expire  (row_expire)
    );

    frp_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_done  (set_done),
        .set_tmo   (set_tmo),
        .clr_wr    (clr_wr),
        .clr_mask  (bus_wdata[1:0]),
        .done_ie   (r_q.done_ie),
        .tmo_ie    (r_q.tmo_ie),
        .done_flag (done_flag),
        .tmo_flag  (tmo_flag),
        .irq       (irq)
    );

    assign col_last      = &r_q.addr[COL_W-1:0];
    assign finishing_row = (r_q.st == ST_PROG) && byte_done && r_q.row_mode && col_last;

    always_comb begin
        r_d        = r_q;
        bus_wait   = 1'b0;
        byte_start = 1'b0;
        row_start  = 1'b0;
        set_done   = 1'b0;
        set_tmo    = 1'b0;
        clr_wr     = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (bus_wr) begin
                    unique case (bus_addr)
                        RA_DATA: if (!tmo_flag) begin
                            bus_wait   = 1'b1;
                            r_d.data   = bus_wdata;
                            r_d.st     = ST_PROG;
                            r_d.hv     = 1'b1;
                            byte_start = 1'b1;
                        end
                        RA_COL:  r_d.addr[COL_W-1:0]        = bus_wdata[COL_W-1:0];
                        RA_ROW:  r_d.addr[ROW_LSB +: ROW_W] = bus_wdata[ROW_W-1:0];
                        RA_PAGE: r_d.addr[PG_LSB +: PAGE_W] = bus_wdata[PAGE_W-1:0];
                        RA_CTRL: begin
                            r_d.done_ie = bus_wdata[CB_DONE_IE];
                            r_d.tmo_ie  = bus_wdata[CB_TMO_IE];
                            if (!bus_wdata[CB_ROW]) begin
                                r_d.row_mode = 1'b0;
                                r_d.hv       = 1'b0;
                            end else if (!r_q.row_mode && !tmo_flag) begin
                                r_d.row_mode = 1'b1;
                                row_start    = 1'b1;
                            end
                        end
                        RA_STAT: clr_wr  = 1'b1;
                        RA_DIV:  r_d.div = bus_wdata[DIV_W-1:0];
                        default: ;
                    endcase
                end else if (bus_rd && bus_addr == RA_DATA) begin
                    r_d.addr = r_q.addr + ADDR_ONE;
                end
            end
            ST_PROG: begin
                bus_wait = !byte_done;
                if (byte_done) begin
                    r_d.st   = ST_IDLE;
                    r_d.addr = r_q.addr + ADDR_ONE;
                    if (!r_q.row_mode) begin
                        r_d.hv = 1'b0;
                    end else if (col_last) begin
                        r_d.row_mode = 1'b0;
                        r_d.hv       = 1'b0;
                        set_done     = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        // Row watchdog abort; a row finishing in the same cycle wins.
        if (r_q.row_mode && row_expire && !finishing_row) begin
            r_d.row_mode = 1'b0;
            r_d.hv       = 1'b0;
            r_d.st       = ST_IDLE;
            bus_wait     = 1'b0;
            set_tmo      = 1'b1;
            set_done     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (bus_addr)
            RA_DATA: bus_rdata = r_q.data;
            RA_COL:  bus_rdata = 8'(r_q.addr[COL_W-1:0]);
            RA_ROW:  bus_rdata = 8'(r_q.addr[ROW_LSB +: ROW_W]);
            RA_PAGE: bus_rdata = 8'(r_q.addr[PG_LSB +: PAGE_W]);
            RA_CTRL: bus_rdata = {5'd0, r_q.tmo_ie, r_q.done_ie, r_q.row_mode};
            RA_STAT: bus_rdata = {6'd0, tmo_flag, done_flag};
            RA_DIV:  bus_rdata = 8'(r_q.div);
            default: bus_rdata = 8'd0;
        endcase
    end

    assign fl_addr = r_q.addr;
    assign fl_data = r_q.data;
    assign fl_prog = (r_q.st == ST_PROG);
    assign fl_hv   = r_q.hv;
endmodule

// File: rtl/frp_checker.sv
module frp_checker #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [2:0]        bus_addr,
    input logic              bus_wait,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_data,
    input logic              fl_prog,
    input logic              fl_hv,
    input logic              row_mode,
    input logic              tmo_flag
);
    p_wait_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> (fl_prog || (bus_wr && bus_addr == 3'd0)));

    p_prog_hv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_prog |-> fl_hv);

    p_row_hv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_mode && $past(row_mode) && $past(fl_hv)) |-> fl_hv);

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> (!fl_hv && !row_mode));

    p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |-> (!fl_prog && !bus_wait));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_prog && $past(fl_prog)) |-> ($stable(fl_addr) && $stable(fl_data)));
endmodule

bind flash_rowprog_ctrl frp_checker #(.ADDR_W(ADDR_W)) u_frp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wait (bus_wait),
    .fl_addr  (fl_addr),
    .fl_data  (fl_data),
    .fl_prog  (fl_prog),
    .fl_hv    (fl_hv),
    .row_mode (r_q.row_mode),
    .tmo_flag (tmo_flag)
);

// File: tb/flash_rowprog_ctrl_bench.sv
module flash_rowprog_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 3, ROW_W = 4, PAGE_W = 2;
    localparam int ADDR_W = COL_W + ROW_W + PAGE_W;
    localparam int BT = 3, TMO = 48;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic bus_wait, fl_prog, fl_hv, irq;
    logic [ADDR_W-1:0] fl_addr;
    logic [7:0] fl_data;

    int n_chk = 0, n_fail = 0;
    int cur_div = 0;
    logic [ADDR_W-1:0] maddr = '0;
    logic [ADDR_W+7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_rowprog_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W), .PAGE_W(PAGE_W), .DIV_W(8),
                         .BYTE_TICKS(BT), .ROW_TMO_TICKS(TMO)) u_flash_rowprog_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
        .fl_addr(fl_addr), .fl_data(fl_data), .fl_prog(fl_prog), .fl_hv(fl_hv), .irq(irq));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bus write; returns the number of cycles the access took.
    task automatic bwr(input logic [2:0] a, input logic [7:0] d, output int n);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        n = 1;
        while (bus_wait) begin
            @(negedge clk);
            #1;
            n++;
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_addr(input int p, input int r, input int c);
        int n;
        bwr(3'd3, 8'(p), n);
        bwr(3'd2, 8'(r), n);
        bwr(3'd1, 8'(c), n);
        maddr = {PAGE_W'(p), ROW_W'(r), COL_W'(c)};
    endtask

    // Driver: a data write; pushes the expected program event when one should happen.
    task automatic data_write(input logic [7:0] d, input bit accepted, input string req);
        int n;
        if (accepted) exp_q.push_back({maddr, d});
        bwr(3'd0, d, n);
        check(req, n, accepted ? 1 + (cur_div + 1) * BT : 1);
        if (accepted) maddr = maddr + 1'b1;
    endtask

    // Monitor: compares each program event against the scoreboard queue (R10).
    logic prev_prog = 1'b0;
    always @(negedge clk) begin
        if (rst_n && fl_prog && !prev_prog) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected program", 1, 0);
            end else begin
                logic [ADDR_W+7:0] e;
                e = exp_q.pop_front();
                check("R10 program address", int'(fl_addr), int'(e[ADDR_W+7:8]));
                check("R10 program data", int'(fl_data), int'(e[7:0]));
            end
        end
        prev_prog = fl_prog;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 hv", int'(fl_hv), 0);
        check("R1 prog", int'(fl_prog), 0);
        check("R1 wait", int'(bus_wait), 0);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        brd(3'd5, rd); check("R1 status", int'(rd), 0);
        brd(3'd4, rd); check("R1 control", int'(rd), 0);
        brd(3'd1, rd); check("R1 column", int'(rd), 0);

        // R2 register access, R3 zero-wait on register writes
        bwr(3'd6, 8'd1, n); cur_div = 1;
        check("R3 register write no wait", n, 1);
        brd(3'd6, rd); check("R2 divider readback", int'(rd), 1);
        set_addr(1, 3, 5);
        brd(3'd2, rd); check("R2 row readback", int'(rd), 3);
        brd(3'd3, rd); check("R2 page readback", int'(rd), 1);

        // Single-byte mode: R3 wait length, R5 hv dropped, R4 increment
        data_write(8'hA5, 1'b1, "R3 single wait length");
        check("R5 hv low after single byte", int'(fl_hv), 0);
        brd(3'd1, rd); check("R4 column after write", int'(rd), 6);
        brd(3'd0, rd); check("R4 data read value", int'(rd), 8'hA5);
        maddr = maddr + 1'b1;
        brd(3'd1, rd); check("R4 column after data read", int'(rd), 7);
        data_write(8'h3C, 1'b1, "R3 single wait at last column");
        brd(3'd1, rd); check("R4 column wraps", int'(rd), 0);
        brd(3'd2, rd); check("R4 carry into row", int'(rd), 4);

        // R3 wait length with a different divider
        bwr(3'd6, 8'd0, n); cur_div = 0;
        data_write(8'h11, 1'b1, "R3 wait length divider 0");
        bwr(3'd6, 8'd1, n); cur_div = 1;

        // Row mode: R6 hv held, completion, R9 interrupt
        set_addr(0, 2, 0);
        bwr(3'd4, 8'h03, n);
        for (int i = 0; i < 8; i++) begin
            data_write(8'(8'h40 + i), 1'b1, "R3 row byte wait");
            if (i < 7) check("R6 hv held between row bytes", int'(fl_hv), 1);
        end
        check("R6 hv dropped at row end", int'(fl_hv), 0);
        brd(3'd4, rd); check("R6 row bit cleared", int'(rd[0]), 0);
        brd(3'd5, rd); check("R6 done flag set", int'(rd), 1);
        check("R9 irq from done", int'(irq), 1);
        brd(3'd2, rd); check("R4 row advanced after row", int'(rd), 3);
        bwr(3'd5, 8'h01, n);
        brd(3'd5, rd); check("R9 done cleared by write one", int'(rd), 0);
        check("R9 irq low after clear", int'(irq), 0);

        // Row time-out: R7 abort, R9 timeout interrupt
        set_addr(2, 5, 0);
        bwr(3'd4, 8'h05, n);
        for (int i = 0; i < 3; i++) data_write(8'(8'h70 + i), 1'b1, "R3 row byte before timeout");
        check("R6 hv held while row open", int'(fl_hv), 1);
        repeat (150) @(negedge clk);
        check("R7 hv dropped on timeout", int'(fl_hv), 0);
        brd(3'd5, rd); check("R7 status after timeout", int'(rd), 3);
        brd(3'd4, rd); check("R7 row bit cleared", int'(rd[0]), 0);
        check("R9 irq from timeout", int'(irq), 1);

        // R8 lock-out while the error flag stands
        data_write(8'hEE, 1'b0, "R8 locked write no wait");
        check("R8 no hv when locked", int'(fl_hv), 0);
        brd(3'd1, rd); check("R8 column unchanged", int'(rd), 3);
        bwr(3'd4, 8'h01, n);
        brd(3'd4, rd); check("R8 row bit refused", int'(rd[0]), 0);
        bwr(3'd5, 8'h02, n);
        brd(3'd5, rd); check("R9 timeout cleared, done remains", int'(rd), 1);
        bwr(3'd5, 8'h01, n);
        data_write(8'h5A, 1'b1, "R8 write accepted after clear");
        brd(3'd1, rd); check("R4 column after unlock", int'(rd), 4);

        repeat (4) @(negedge clk);
        check("R10 all program events seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule